// File: doc/BRIEF.md
# Sixteen-Bit Flag-Producing ALU

This block is the combinational arithmetic and logic stage for a processor whose instructions name two 16-bit registers. The first register is called Rn here and the second Rm. The stage takes a 6-bit opcode and both register values. It returns the value to write back into Rn, a write enable for that value, and new values for the zero (ZF), carry (CA) and overflow (OV) flags. Each flag has its own write enable. The flag register outside the block updates only the flags whose enable is high, so the other flags keep their old values.

The stage handles five kinds of operation:
- bitwise logic;
- logical shifts and rotates, with the count taken from the four low bits of Rm;
- addition and subtraction;
- an unsigned 16x16 multiply that keeps the low half of the product;
- exchanging the two bytes of Rn.

Opcodes the stage does not implement produce no writes at all, so the surrounding decoder can send every instruction through the stage.

Top module: `alu16_core`

## Requirements
- R1: The bitwise opcodes produce these results and write Rn: 0x0B gives ~Rn, 0x0C gives Rn&Rm, 0x0D gives Rn|Rm, 0x0E gives Rn^Rm, 0x0F gives ~(Rn|Rm). Each of them writes ZF only.
- R2: Opcode 0x0A returns Rn with its upper byte (bits 15:8) and lower byte (bits 7:0) exchanged. It writes the result and no flag.
- R3: Opcode 0x10 shifts Rn right logically, filling with zeros. Opcode 0x11 shifts Rn left. Both use Rm[3:0] as the count and ignore Rm[15:4]. Opcode 0x10 writes ZF only. Opcode 0x11 writes ZF and CA, where CA is the last bit moved out past bit 15, and a count of 0 clears CA.
- R4: Opcode 0x12 rotates Rn right and opcode 0x13 rotates Rn left, each by Rm[3:0]. Neither writes any flag.
- R5: Opcode 0x14 returns Rn+Rm modulo 2^16. CA is the unsigned carry out. OV is set when the signed two's-complement sum lies outside -32768..32767.
- R6: Opcode 0x15 returns Rn-Rm modulo 2^16. CA is the borrow, set exactly when Rn < Rm unsigned. OV is set when the signed difference lies outside -32768..32767.
- R7: Opcode 0x16 returns the low 16 bits of the unsigned product Rn*Rm. It writes CA and OV, both set exactly when the upper 16 bits of the 32-bit product are nonzero. It does not write ZF.
- R8: Whenever ZF is written, its value is 1 exactly when the returned 16-bit result is zero.
- R9: The OV enable is high only for 0x14, 0x15 and 0x16. The CA enable is high only for 0x11, 0x14, 0x15 and 0x16. The ZF enable is high for 0x0B through 0x11, 0x14 and 0x15.
- R10: Any opcode other than 0x0A through 0x16 drives the result write enable and all three flag enables low, and drives the result to zero.
- R11: When a flag's write enable is low, the flag's value output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Operation code |
| rn_i | input | 16 | First operand, and the register that receives the result |
| rm_i | input | 16 | Second operand; its low four bits are the shift or rotate count |
| res_o | output | 16 | Value to write back into Rn |
| res_we_o | output | 1 | Result write enable |
| zf_o | output | 1 | New zero flag |
| zf_we_o | output | 1 | Zero flag write enable |
| ca_o | output | 1 | New carry/borrow flag |
| ca_we_o | output | 1 | Carry flag write enable |
| ov_o | output | 1 | New overflow flag |
| ov_we_o | output | 1 | Overflow flag write enable |

## Verification
The stage holds no state, so any fault in its decode or datapath shows up at the ports for the same inputs that trigger it, within the cycle those inputs are applied. A mis-decoded opcode appears as a wrong set of write enables. For example, a rotate that raises a flag enable would corrupt the flag register outside the block. A faulty carry or overflow chain appears as a wrong CA or OV only at boundary operands, so the stimulus concentrates on those: the signed limits, an all-ones sum, zero minus one, a product just past 16 bits, and shift counts of zero or with upper bits set in Rm.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int OPW = 6;

  typedef enum logic [OPW-1:0] {
    OP_BSWP = 6'h0A,
    OP_INV  = 6'h0B,
    OP_BAND = 6'h0C,
    OP_BOR  = 6'h0D,
    OP_BXOR = 6'h0E,
    OP_BNOR = 6'h0F,
    OP_LSR  = 6'h10,
    OP_LSL  = 6'h11,
    OP_RTR  = 6'h12,
    OP_RTL  = 6'h13,
    OP_SUM  = 6'h14,
    OP_DIFF = 6'h15,
    OP_PROD = 6'h16
  } alu_op_e;
endpackage

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (op_i)
      OP_INV:  res_o = ~a_i;
      OP_BAND: res_o = a_i & b_i;
      OP_BOR:  res_o = a_i | b_i;
      OP_BXOR: res_o = a_i ^ b_i;
      OP_BNOR: res_o = ~(a_i | b_i);
      OP_BSWP: res_o = {a_i[HALF-1:0], a_i[W-1:HALF]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPW-1:0]         op_i,
  input  logic [W-1:0]           a_i,
  input  logic [$clog2(W)-1:0]   amt_i,
  output logic [W-1:0]           res_o,
  output logic                   co_o
);
  logic [W:0]     lsl_ext;
  logic [2*W-1:0] dbl_r;
  logic [2*W-1:0] dbl_l;

  always_comb begin
    lsl_ext = {1'b0, a_i} << amt_i;
    dbl_r   = {a_i, a_i} >> amt_i;
    dbl_l   = {a_i, a_i} << amt_i;
    co_o    = 1'b0;
    unique case (op_i)
      OP_LSR:  res_o = a_i >> amt_i;
      OP_LSL: begin
        res_o = lsl_ext[W-1:0];
        co_o  = lsl_ext[W];
      end
      OP_RTR:  res_o = dbl_r[W-1:0];
      OP_RTL:  res_o = dbl_l[2*W-1:W];
      default: res_o = '0;
    endcase
  end

  // R4
  always_comb begin
    if (op_i == OP_RTR) begin
      rot_inverse_chk: assert (((res_o << amt_i) | (res_o >> (W - int'(amt_i)))) == a_i ||
                               amt_i == '0);
    end
  end
endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           ca_o,
  output logic           ov_o
);
  logic [W:0]     add_ext;
  logic [W:0]     sub_ext;
  logic [2*W-1:0] prod;

  always_comb begin
    add_ext = {1'b0, a_i} + {1'b0, b_i};
    sub_ext = {1'b0, a_i} - {1'b0, b_i};
    prod    = a_i * b_i;
    unique case (op_i)
      OP_SUM: begin
        res_o = add_ext[W-1:0];
        ca_o  = add_ext[W];
        ov_o  = (a_i[W-1] == b_i[W-1]) && (add_ext[W-1] != a_i[W-1]);
      end
      OP_DIFF: begin
        res_o = sub_ext[W-1:0];
        ca_o  = sub_ext[W];
        ov_o  = (a_i[W-1] != b_i[W-1]) && (sub_ext[W-1] != a_i[W-1]);
      end
      OP_PROD: begin
        res_o = prod[W-1:0];
        ca_o  = |prod[2*W-1:W];
        ov_o  = ca_o;
      end
      default: begin
        res_o = '0;
        ca_o  = 1'b0;
        ov_o  = 1'b0;
      end
    endcase
  end

  // R6
  always_comb begin
    if (op_i == OP_DIFF) begin
      borrow_cmp_chk: assert (ca_o == (a_i < b_i));
    end
  end

  // R5
  always_comb begin
    if (op_i == OP_SUM) begin
      carry_wrap_chk: assert (ca_o == (res_o < a_i));
    end
  end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   rn_i,
  input  logic [W-1:0]   rm_i,
  output logic [W-1:0]   res_o,
  output logic           res_we_o,
  output logic           zf_o,
  output logic           zf_we_o,
  output logic           ca_o,
  output logic           ca_we_o,
  output logic           ov_o,
  output logic           ov_we_o
);
  localparam int SW = $clog2(W);

  typedef enum logic [1:0] {SRC_NONE, SRC_LOGIC, SRC_SHIFT, SRC_ARITH} src_e;

  logic [W-1:0] lg_res, sh_res, ar_res;
  logic         sh_co, ar_ca, ar_ov;
  src_e         src;
  logic         ca_raw;

  alu16_logic #(.W(W)) u_logic (
    .op_i (op_i), .a_i (rn_i), .b_i (rm_i), .res_o (lg_res)
  );

  alu16_shift #(.W(W)) u_shift (
    .op_i (op_i), .a_i (rn_i), .amt_i (rm_i[SW-1:0]),
    .res_o (sh_res), .co_o (sh_co)
  );

  alu16_arith #(.W(W)) u_arith (
    .op_i (op_i), .a_i (rn_i), .b_i (rm_i),
    .res_o (ar_res), .ca_o (ar_ca), .ov_o (ar_ov)
  );

  always_comb begin
    src     = SRC_NONE;
    zf_we_o = 1'b0;
    ca_we_o = 1'b0;
    ov_we_o = 1'b0;
    unique case (op_i)
      OP_BSWP:                                src = SRC_LOGIC;
      OP_INV, OP_BAND, OP_BOR, OP_BXOR, OP_BNOR: begin
        src = SRC_LOGIC; zf_we_o = 1'b1;
      end
      OP_LSR: begin src = SRC_SHIFT; zf_we_o = 1'b1; end
      OP_LSL: begin src = SRC_SHIFT; zf_we_o = 1'b1; ca_we_o = 1'b1; end
      OP_RTR, OP_RTL:                         src = SRC_SHIFT;
      OP_SUM, OP_DIFF: begin
        src = SRC_ARITH; zf_we_o = 1'b1; ca_we_o = 1'b1; ov_we_o = 1'b1;
      end
      OP_PROD: begin src = SRC_ARITH; ca_we_o = 1'b1; ov_we_o = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (src)
      SRC_LOGIC: begin res_o = lg_res; ca_raw = 1'b0; end
      SRC_SHIFT: begin res_o = sh_res; ca_raw = sh_co; end
      SRC_ARITH: begin res_o = ar_res; ca_raw = ar_ca; end
      default:   begin res_o = '0;     ca_raw = 1'b0; end
    endcase
    res_we_o = (src != SRC_NONE);
    zf_o     = zf_we_o && (res_o == '0);
    ca_o     = ca_we_o && ca_raw;
    ov_o     = ov_we_o && ar_ov;
  end

  // R9
  always_comb begin
    ov_needs_ca_chk: assert (!ov_we_o || ca_we_o);
  end

  // R10
  always_comb begin
    idle_quiet_chk: assert (res_we_o || (!zf_we_o && !ca_we_o && !ov_we_o && res_o == '0));
  end

  // R7
  always_comb begin
    if (op_i == OP_PROD) begin
      prod_flag_pair_chk: assert (ca_o == ov_o && !zf_we_o);
    end
  end
endmodule

// File: tb/alu16_core_test.sv
module alu16_core_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   op;
  logic [W-1:0] rn, rm;
  logic [W-1:0] res;
  logic         res_we, zf, zf_we, ca, ca_we, ov, ov_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [22:0] v;
    string       tag;
  } item_t;

  item_t sb[$];

  always #5 clk = ~clk;

  alu16_core #(.W(W)) uut (
    .op_i (op), .rn_i (rn), .rm_i (rm),
    .res_o (res), .res_we_o (res_we),
    .zf_o (zf), .zf_we_o (zf_we),
    .ca_o (ca), .ca_we_o (ca_we),
    .ov_o (ov), .ov_we_o (ov_we)
  );

  function automatic logic [22:0] model(logic [5:0] o, logic [15:0] a, logic [15:0] b);
    logic [15:0] r = 16'h0;
    logic rw = 1'b1, zw = 1'b0, cw = 1'b0, vw = 1'b0, c = 1'b0, v = 1'b0;
    int amt = int'(b & 16'h000F);
    int sa = int'($signed(a));
    int sb2 = int'($signed(b));
    int s;
    logic [31:0] p;
    case (o)
      6'h0A: r = {a[7:0], a[15:8]};
      6'h0B: begin r = ~a; zw = 1; end
      6'h0C: begin r = a & b; zw = 1; end
      6'h0D: begin r = a | b; zw = 1; end
      6'h0E: begin r = a ^ b; zw = 1; end
      6'h0F: begin r = ~(a | b); zw = 1; end
      6'h10: begin
        r = a; zw = 1;
        for (int i = 0; i < amt; i++) r = {1'b0, r[15:1]};
      end
      6'h11: begin
        r = a; zw = 1; cw = 1;
        for (int i = 0; i < amt; i++) begin c = r[15]; r = {r[14:0], 1'b0}; end
      end
      6'h12: begin r = a; for (int i = 0; i < amt; i++) r = {r[0], r[15:1]}; end
      6'h13: begin r = a; for (int i = 0; i < amt; i++) r = {r[14:0], r[15]}; end
      6'h14: begin
        r = a + b; zw = 1; cw = 1; vw = 1;
        c = (int'(a) + int'(b)) > 65535;
        s = sa + sb2; v = (s > 32767) || (s < -32768);
      end
      6'h15: begin
        r = a - b; zw = 1; cw = 1; vw = 1;
        c = a < b;
        s = sa - sb2; v = (s > 32767) || (s < -32768);
      end
      6'h16: begin
        p = 32'(a) * 32'(b); r = p[15:0]; cw = 1; vw = 1;
        c = p > 32'h0000FFFF; v = c;
      end
      default: begin rw = 0; r = 16'h0; end
    endcase
    return {rw, r, zw, zw && (r == 16'h0), cw, c, vw, v};
  endfunction

  task automatic drive(input logic [5:0] o, input logic [15:0] a, input logic [15:0] b,
                       input string tag);
    item_t it;
    @(posedge clk);
    #1;
    op = o; rn = a; rm = b;
    it.v = model(o, a, b);
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t it;
      logic [22:0] act;
      it  = sb.pop_front();
      act = {res_we, res, zf_we, zf, ca_we, ca, ov_we, ov};
      checks++;
      if (act !== it.v) begin
        fails++;
        $display("FAIL %s op=%h rn=%h rm=%h actual=%h expected=%h",
                 it.tag, op, rn, rm, act, it.v);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    op = 6'h00; rn = 16'h0; rm = 16'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10 idle state
    drive(6'h00, 16'h0000, 16'h0000, "R10 reset/noop");
    // R1
    drive(6'h0B, 16'h00FF, 16'h1234, "R1 not");
    drive(6'h0B, 16'hFFFF, 16'h0000, "R1 R8 not zero");
    drive(6'h0C, 16'hF0F0, 16'h3C3C, "R1 and");
    drive(6'h0C, 16'hF0F0, 16'h0F0F, "R1 R8 and zero");
    drive(6'h0D, 16'h1200, 16'h0034, "R1 or");
    drive(6'h0E, 16'hA5A5, 16'hA5A5, "R1 R8 xor zero");
    drive(6'h0F, 16'h1111, 16'h2222, "R1 nor");
    // R2
    drive(6'h0A, 16'hAB12, 16'hFFFF, "R2 swap");
    drive(6'h0A, 16'h0000, 16'h0000, "R2 swap zero no flag");
    // R3
    drive(6'h10, 16'h8000, 16'h000F, "R3 shr 15");
    drive(6'h10, 16'h8421, 16'hFFF4, "R3 shr masked");
    drive(6'h10, 16'h0001, 16'h0001, "R3 R8 shr to zero");
    drive(6'h11, 16'h8001, 16'h0001, "R3 shl carry");
    drive(6'h11, 16'hFFFF, 16'h0000, "R3 shl count0 clears CA");
    drive(6'h11, 16'h0001, 16'h0010, "R3 shl count masked to 0");
    drive(6'h11, 16'h4000, 16'h0002, "R3 R8 shl to zero carry");
    drive(6'h11, 16'h0003, 16'h000E, "R3 shl 14");
    // R4
    drive(6'h12, 16'h1234, 16'h0004, "R4 ror");
    drive(6'h12, 16'h8001, 16'h0013, "R4 ror masked");
    drive(6'h13, 16'h1234, 16'h0004, "R4 rol");
    drive(6'h13, 16'h0000, 16'h0005, "R4 rol zero no flag");
    // R5
    drive(6'h14, 16'h0005, 16'h0003, "R5 add");
    drive(6'h14, 16'h7FFF, 16'h0001, "R5 add ov");
    drive(6'h14, 16'hFFFF, 16'h0001, "R5 R8 add carry zero");
    drive(6'h14, 16'h8000, 16'h8000, "R5 add ov carry");
    // R6
    drive(6'h15, 16'h0000, 16'h0001, "R6 sub borrow");
    drive(6'h15, 16'h8000, 16'h0001, "R6 sub ov");
    drive(6'h15, 16'h1234, 16'h1234, "R6 R8 sub zero");
    drive(6'h15, 16'h7FFF, 16'hFFFF, "R6 sub ov borrow");
    // R7
    drive(6'h16, 16'h00FF, 16'h00FF, "R7 mul fits");
    drive(6'h16, 16'h0100, 16'h0100, "R7 mul overflow low zero");
    drive(6'h16, 16'hFFFF, 16'h0000, "R7 mul zero");
    drive(6'h16, 16'h8001, 16'h0003, "R7 mul wide");
    // R9 R10 R11
    drive(6'h17, 16'hFFFF, 16'h0001, "R10 undecoded 0x17");
    drive(6'h09, 16'h1234, 16'h0000, "R10 undecoded 0x09");
    drive(6'h3F, 16'hFFFF, 16'hFFFF, "R10 R11 undecoded 0x3F");
    drive(6'h13, 16'hFFFF, 16'h0001, "R9 R11 rol flags idle");
    drive(6'h10, 16'hFFFF, 16'h0000, "R9 R11 shr no ca");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule